// File: doc/BRIEF.md
# Raster Beam Position Counter

This block tracks where the beam is on a raster display. An X counter steps once for each pixel-clock enable and rolls over at a programmable last column. Each rollover advances a Y counter, which rolls over at a programmable last line. When both counters roll over together, a one-cycle frame-start pulse follows. Two programmable windows, one for columns and one for lines, drive the horizontal and vertical active outputs.

Software reaches the block through a small word-addressed bus. Reads are combinational and writes are single-cycle. The position word holds a freeze flag above the packed Y and X values. Setting that flag stops both counters, so software can read a position that does not change while it reads. Clearing the flag lets counting resume from the held point.

Top module: `raster_pos_counter`

## Requirements
- R1: Address 0 reads the position word: the freeze flag in bit 31, Y in bits 23..12, X in bits 11..0, and zero in all other bits.
- R2: A write to address 0 loads the freeze flag from bit 31 of the write data. The other bits of the write data have no effect on X or Y.
- R3: On each cycle with `pix_en` high and freeze clear, X increments by one. If X is at or above the last column, it instead returns to 0 and Y advances. If Y is also at or above the last line, Y returns to 0.
- R4: `frame_start` is high for exactly the one cycle after an advance that returned both X and Y to 0.
- R5: While freeze is set, X and Y hold their values. Once freeze is cleared, counting continues from the held values.
- R6: Address 2 holds the column window, with the first column in bits 23..12 and the last column in bits 11..0. `h_active` is high exactly when first ≤ X ≤ last.
- R7: Address 3 holds the line window in the same layout. `v_active` is high exactly when first ≤ Y ≤ last.
- R8: Address 1 holds the limits, with the last line in bits 23..12 and the last column in bits 11..0. It can be read and written, and bits 31..24 read as zero.
- R9: After reset, freeze is clear, X and Y are 0, and the limits read (YRES-1, XRES-1). The column window reads (0, XRES-1) and the line window reads (0, YRES-1).
- R10: With `pix_en` low, X and Y do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| h_active | output | 1 | X lies inside the column window |
| v_active | output | 1 | Y lies inside the line window |
| frame_start | output | 1 | One-cycle pulse after a full-frame rollover |

## Verification
The bench builds the block with XRES=10 and YRES=6 instead of 640x480. At that size, every column and line rollover and many frame-start pulses fall within a few hundred cycles. The small frame also makes it possible to reach a limit of zero in both directions, where a pulse follows every advance. It also makes it possible to lower the limits below the current position, which tests the at-or-above rollover rule.

// File: rtl/raster_pos_counter.sv
module raster_pos_counter #(
  parameter int XRES = 640,
  parameter int YRES = 480,
  parameter int CW   = 12,
  parameter int AW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          h_active,
  output logic          v_active,
  output logic          frame_start
);

  localparam logic [AW-1:0] A_POS  = AW'(0);
  localparam logic [AW-1:0] A_LIM  = AW'(1);
  localparam logic [AW-1:0] A_HWIN = AW'(2);
  localparam logic [AW-1:0] A_VWIN = AW'(3);
  localparam logic [CW-1:0] LAST_X = CW'(XRES - 1);
  localparam logic [CW-1:0] LAST_Y = CW'(YRES - 1);
  localparam int            PADP   = 31 - 2*CW;
  localparam int            PADW   = 32 - 2*CW;

  logic [CW-1:0] x, y, max_x, max_y, h_on, h_off, v_on, v_off;
  logic          frozen;

  wire adv   = pix_en & ~frozen;
  wire x_end = x >= max_x;
  wire y_end = y >= max_y;
  wire wr    = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x           <= '0;
      y           <= '0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= adv & x_end & y_end;
      if (adv) begin
        if (x_end) begin
          x <= '0;
          y <= y_end ? '0 : y + 1'b1;
        end else begin
          x <= x + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen <= 1'b0;
      max_x  <= LAST_X;
      max_y  <= LAST_Y;
      h_on   <= '0;
      h_off  <= LAST_X;
      v_on   <= '0;
      v_off  <= LAST_Y;
    end else if (wr) begin
      case (bus_addr)
        A_POS:  frozen <= bus_wdata[31];
        A_LIM:  {max_y, max_x} <= bus_wdata[2*CW-1:0];
        A_HWIN: {h_on, h_off}  <= bus_wdata[2*CW-1:0];
        A_VWIN: {v_on, v_off}  <= bus_wdata[2*CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_POS:   bus_rdata = {frozen, {PADP{1'b0}}, y, x};
      A_LIM:   bus_rdata = {{PADW{1'b0}}, max_y, max_x};
      A_HWIN:  bus_rdata = {{PADW{1'b0}}, h_on, h_off};
      A_VWIN:  bus_rdata = {{PADW{1'b0}}, v_on, v_off};
      default: bus_rdata = '0;
    endcase
  end

  assign h_active = (x >= h_on) && (x <= h_off);
  assign v_active = (y >= v_on) && (y <= v_off);

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en || frozen) |=> ($stable(x) && $stable(y)));  // R5

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !frozen && x < max_x) |=> (x == $past(x) + 1'b1));  // R3

  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !frozen && x >= max_x) |=> (x == '0));  // R3

  AST_FRAME_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (x == '0 && y == '0));  // R4

  AST_FREEZE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_POS) |=> (frozen == $past(bus_wdata[31])));  // R2

endmodule

// File: tb/sim_raster_pos_counter.sv
module sim_raster_pos_counter;
  localparam int CLK_P = 10;
  localparam int XR = 10;
  localparam int YR = 6;

  logic clk = 1'b0, rst_n = 1'b0, pix_en = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic h_active, v_active, frame_start;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  raster_pos_counter #(.XRES(XR), .YRES(YR), .CW(12), .AW(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .h_active(h_active), .v_active(v_active), .frame_start(frame_start));

  int mx, my, mxp, myp, hon, hoff, von, voff, fr, fs;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mx = 0; my = 0; mxp = XR-1; myp = YR-1;
      hon = 0; hoff = XR-1; von = 0; voff = YR-1; fr = 0; fs = 0;
    end else begin
      int nx, ny, nfs;
      nx = mx; ny = my; nfs = 0;
      if (pix_en && !fr) begin
        if (mx >= mxp) begin
          nx = 0;
          if (my >= myp) begin ny = 0; nfs = 1; end
          else ny = my + 1;
        end else nx = mx + 1;
      end
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          2'd0: fr = bus_wdata[31];
          2'd1: begin myp = (bus_wdata >> 12) & 12'hFFF; mxp = bus_wdata & 12'hFFF; end
          2'd2: begin hon = (bus_wdata >> 12) & 12'hFFF; hoff = bus_wdata & 12'hFFF; end
          default: begin von = (bus_wdata >> 12) & 12'hFFF; voff = bus_wdata & 12'hFFF; end
        endcase
      end
      mx = nx; my = ny; fs = nfs;
    end
  end

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return (32'(fr) << 31) | (32'(my) << 12) | 32'(mx);
      2'd1: return (32'(myp) << 12) | 32'(mxp);
      2'd2: return (32'(hon) << 12) | 32'(hoff);
      default: return (32'(von) << 12) | 32'(voff);
    endcase
  endfunction

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      case (bus_addr)
        2'd0: chk("R3 position", bus_rdata, exp_rd(2'd0));
        2'd1: chk("R8 limits", bus_rdata, exp_rd(2'd1));
        2'd2: chk("R6 column window", bus_rdata, exp_rd(2'd2));
        default: chk("R7 line window", bus_rdata, exp_rd(2'd3));
      endcase
      chk("R6 h_active", 32'(h_active), 32'(mx >= hon && mx <= hoff));
      chk("R7 v_active", 32'(v_active), 32'(my >= von && my <= voff));
      chk("R4 frame_start", 32'(frame_start), 32'(fs));
    end
  end

  task automatic run(int n, int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'(i);
      pix_en = (pat == 0) ? 1'b1 : (pat == 1) ? 1'b0 : ((i % pat) != 0);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, logic pe);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; pix_en = pe;
    @(negedge clk);
    bus_wr = 1'b0; pix_en = 1'b0;
  endtask

  function automatic logic [31:0] rd_now(logic [1:0] a);
    bus_addr = a; bus_wr = 1'b0; bus_sel = 1'b1;
    return 32'hx;
  endfunction

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; pix_en = 1'b0;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] d, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, d); chk("R9 position after reset", d, 32'h0);
    rd(2'd1, d); chk("R9 limits after reset", d, ((YR-1) << 12) | (XR-1));
    rd(2'd2, d); chk("R9 column window after reset", d, 32'(XR-1));
    rd(2'd3, d); chk("R9 line window after reset", d, 32'(YR-1));
    run(200, 0);
    run(150, 3);
    wr(2'd2, (3 << 12) | 6, 1'b1);
    wr(2'd3, (1 << 12) | 2, 1'b1);
    run(150, 0);
    rd(2'd0, p0);
    run(10, 1);
    rd(2'd0, d); chk("R10 hold without enable", d, p0);
    wr(2'd0, 32'h8000_0ABC, 1'b0);
    rd(2'd0, d); chk("R2 freeze write leaves position", d, (p0 & 32'h00FF_FFFF) | 32'h8000_0000);
    chk("R1 freeze flag in bit 31", d[31], 1'b1);
    run(25, 0);
    rd(2'd0, d); chk("R5 frozen position held", d, (p0 & 32'h00FF_FFFF) | 32'h8000_0000);
    wr(2'd0, 32'h7FFF_FFFF, 1'b0);
    run(60, 0);
    wr(2'd1, (1 << 12) | 2, 1'b1);
    run(40, 0);
    wr(2'd1, 32'h0, 1'b1);
    run(20, 0);
    run(20, 2);
    wr(2'd1, 32'hFF00_0000 | ((YR-1) << 12) | (XR-1), 1'b1);
    rd(2'd1, d); chk("R8 upper bits read zero", d, ((YR-1) << 12) | (XR-1));
    run(200, 0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule